// File: doc/BRIEF.md
# Block-Transfer Aware Data Buffer Enable Controller

This block drives the enables of the data buffers that join a processor's local data bus to three buffered segments: the RAM segment, the ROM/I-O segment and a user expansion segment. It also drives two crossover paths that are only used during software-driven block transfers. The first joins the RAM segment, where the blit accelerator sits, to the ROM segment. The second joins the user segment to on-board RAM, so that a device on the user segment can reach memory.

In ordinary bus cycles, the region chip selects from the address decoder pick one segment buffer. During a block transfer the processor must be cut off from the system bus, and only the crossover that matches the accelerator-select bit may open. The raw block-transfer indication can change during T4 of the cycle before the transfer. It is therefore qualified with the bus status code and registered once per bus cycle, using the cycle-start (address strobe) input. Every enable is gated last by the processor's data-buffer enable, so all buffers close when that enable drops in the middle of T4.

Top module: `bufen_ctrl`

## Requirements
- R1: The registered block-mode flag loads only on a rising clock edge at which `cyc_start` is high. At every other edge it keeps its value, so changes of `blt_raw` or `bus_status` between cycle starts have no effect on the outputs.
- R2: The flag loads 1 only if `blt_raw` is 1 and `bus_status` is 4'b1010 or 4'b1011. Any other status code, or `blt_raw` at 0, loads 0.
- R3: Outside block mode, with `dbe` high, `en_rom_bus` is 1 exactly when none of `sel_sram`, `sel_dram`, `sel_user0` and `sel_user1` is 1.
- R4: Outside block mode, with `dbe` high, `en_ram_bus` is 1 exactly when `sel_sram` or `sel_dram` is 1.
- R5: Outside block mode, with `dbe` high, `en_user_bus` is 1 exactly when `sel_user0` or `sel_user1` is 1 and neither RAM select is 1. A RAM select wins over a user select.
- R6: In block mode, `en_rom_bus`, `en_ram_bus` and `en_user_bus` are all 0.
- R7: `en_board_xfer` is 1 exactly when the block mode is set, `accel_sel` is 1, `sel_rom` is 1 and `dbe` is 1.
- R8: `en_user_xfer` is 1 exactly when the block mode is set, `accel_sel` is 0, `sel_sram` or `sel_dram` is 1, and `dbe` is 1.
- R9: While `dbe` is 0, all five enables are 0, whatever the mode and selects are.
- R10: At most one of the five enables is 1 in any clock.
- R11: A synchronous reset (`rst_n` low at a clock edge) clears the block-mode flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_start | input | 1 | Address strobe, high during T1 of a bus cycle |
| bus_status | input | 4 | Bus status code of the current cycle |
| blt_raw | input | 1 | Unsynchronised block-transfer indication, active high |
| accel_sel | input | 1 | 1: accelerator on RAM segment; 0: device on user segment |
| sel_rom | input | 1 | ROM region selected |
| sel_sram | input | 1 | SRAM region selected |
| sel_dram | input | 1 | DRAM region selected |
| sel_user0 | input | 1 | First user region selected |
| sel_user1 | input | 1 | Second user region selected |
| dbe | input | 1 | Processor data-buffer enable, active high |
| en_rom_bus | output | 1 | ROM/I-O segment buffer enable |
| en_ram_bus | output | 1 | RAM segment buffer enable |
| en_user_bus | output | 1 | User segment buffer enable |
| en_board_xfer | output | 1 | RAM-to-ROM segment crossover enable |
| en_user_xfer | output | 1 | User-to-RAM segment crossover enable |

## Verification
The decode is tried with every single region select, with no select at all, and with a RAM and a user select together. This tells the default ROM routing apart from the two selected routes and shows the RAM-over-user priority. Block mode is tried with both values of the accelerator bit against ROM, SRAM and DRAM selects, which separates the two crossovers from the cases where both stay closed. Status codes outside the accepted pair, and `blt_raw` toggled without a cycle start, show that qualification and the per-cycle load are both needed. Pulling `dbe` low in each mode shows that the final gate closes every path.

// File: rtl/bufen_pkg.sv
// Package: shared types for the buffer enable controller.
// Assumes all selects and enables are active high inside the block.
package bufen_pkg;
    localparam int NUM_EN = 5;

    // One enable per buffer path; bit order fixed for the gate stage.
    typedef struct packed {
        logic rom;
        logic ram;
        logic user;
        logic board_x;
        logic user_x;
    } buf_en_t;

    // Region selects from the address decoder.
    typedef struct packed {
        logic rom;
        logic sram;
        logic dram;
        logic user0;
        logic user1;
    } region_sel_t;
endpackage

// File: rtl/bufen_blt_sync.sv
// Module: qualifies the raw block-transfer indication against a list of
// status codes and registers it once per bus cycle, at the edge where the
// cycle-start strobe is sampled high. Assumes cyc_start is high for T1 only.
module bufen_blt_sync #(
    parameter int STATUS_W  = 4,
    parameter int NUM_CODES = 2,
    parameter logic [NUM_CODES*STATUS_W-1:0] CODES = {4'b1011, 4'b1010}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_start,
    input  logic [STATUS_W-1:0] bus_status,
    input  logic                blt_raw,
    output logic                blt_mode
);
    logic [NUM_CODES-1:0] code_hit;
    logic                 qualified;

    // One comparator per accepted block-transfer status code.
    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        assign code_hit[i] = (bus_status == CODES[i*STATUS_W +: STATUS_W]);
    end

    // Raw indication counts only with a matching status code.
    assign qualified = blt_raw & (|code_hit);

    // Load the mode flag at the cycle-start edge, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blt_mode <= 1'b0;
        else if (cyc_start)
            blt_mode <= qualified;
    end

    p_hold_between_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(blt_mode));
    p_raw_low_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !blt_raw) |=> !blt_mode);
    p_reset_clears_r11: assert property (@(posedge clk)
        !rst_n |=> !blt_mode);
endmodule

// File: rtl/bufen_route.sv
// Module: combinational route decode. Picks one segment buffer in ordinary
// cycles, or one crossover in block mode. Assumes the data-buffer enable
// is applied afterwards by the gate stage.
module bufen_route
    import bufen_pkg::*;
(
    input  logic        blt_mode,
    input  logic        accel_sel,
    input  region_sel_t sel,
    output buf_en_t     route
);
    logic any_ram;
    logic any_user;

    // Fold the region selects into segment groups.
    assign any_ram  = sel.sram | sel.dram;
    assign any_user = sel.user0 | sel.user1;

    // Route decode: segment buffers normally, crossovers in block mode.
    always_comb begin
        route = '0;
        if (blt_mode) begin
            route.board_x = accel_sel & sel.rom;
            route.user_x  = ~accel_sel & any_ram;
        end else begin
            route.ram  = any_ram;
            route.user = any_user & ~any_ram;
            route.rom  = ~any_ram & ~any_user;
        end
    end
endmodule

// File: rtl/bufen_gate.sv
// Module: final qualification of every enable by the processor
// data-buffer enable, kept out of the decode so the buffers close as
// soon as that enable drops.
module bufen_gate #(
    parameter int N = 5
) (
    input  logic [N-1:0] en_in,
    input  logic         dbe,
    output logic [N-1:0] en_out
);
    // One AND gate per buffer enable.
    for (genvar i = 0; i < N; i++) begin : g_and
        assign en_out[i] = en_in[i] & dbe;
    end
endmodule

// File: rtl/bufen_ctrl.sv
// Module: top of the buffer enable controller. Joins the block-mode
// synchroniser, the route decode and the final gate stage.
// Assumes the address decoder's selects are stable while dbe is high.
module bufen_ctrl
    import bufen_pkg::*;
#(
    parameter int STATUS_W  = 4,
    parameter int NUM_CODES = 2,
    parameter logic [NUM_CODES*STATUS_W-1:0] BLT_CODES = {4'b1011, 4'b1010}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_start,
    input  logic [STATUS_W-1:0] bus_status,
    input  logic                blt_raw,
    input  logic                accel_sel,
    input  logic                sel_rom,
    input  logic                sel_sram,
    input  logic                sel_dram,
    input  logic                sel_user0,
    input  logic                sel_user1,
    input  logic                dbe,
    output logic                en_rom_bus,
    output logic                en_ram_bus,
    output logic                en_user_bus,
    output logic                en_board_xfer,
    output logic                en_user_xfer
);
    logic        blt_mode;
    region_sel_t sel;
    buf_en_t     route;
    buf_en_t     gated;

    // Pack the decoder selects into the shared struct.
    assign sel = '{rom: sel_rom, sram: sel_sram, dram: sel_dram,
                   user0: sel_user0, user1: sel_user1};

    bufen_blt_sync #(
        .STATUS_W (STATUS_W),
        .NUM_CODES(NUM_CODES),
        .CODES    (BLT_CODES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .bus_status(bus_status),
        .blt_raw   (blt_raw),
        .blt_mode  (blt_mode)
    );

    bufen_route u_route (
        .blt_mode (blt_mode),
        .accel_sel(accel_sel),
        .sel      (sel),
        .route    (route)
    );

    bufen_gate #(.N(NUM_EN)) u_gate (
        .en_in (route),
        .dbe   (dbe),
        .en_out(gated)
    );

    // Unpack the gated enables onto the ports.
    assign en_rom_bus    = gated.rom;
    assign en_ram_bus    = gated.ram;
    assign en_user_bus   = gated.user;
    assign en_board_xfer = gated.board_x;
    assign en_user_xfer  = gated.user_x;

    p_at_most_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_rom_bus, en_ram_bus, en_user_bus, en_board_xfer, en_user_xfer}));
    p_dbe_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dbe |-> !(en_rom_bus | en_ram_bus | en_user_bus | en_board_xfer | en_user_xfer));
    p_blt_isolates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blt_mode |-> !(en_rom_bus | en_ram_bus | en_user_bus));
    p_board_x_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_board_xfer |-> (blt_mode && accel_sel && sel_rom));
    p_user_x_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_user_xfer |-> (blt_mode && !accel_sel && (sel_sram || sel_dram)));
    p_ram_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!blt_mode && dbe && (sel_sram || sel_dram)) |-> en_ram_bus);
endmodule

// File: tb/bufen_ctrl_test.sv
// Directed bench for bufen_ctrl: one task per scenario.
module bufen_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic [3:0] bus_status = 4'h0;
    logic       blt_raw = 1'b0;
    logic       accel_sel = 1'b0;
    logic       sel_rom = 1'b0, sel_sram = 1'b0, sel_dram = 1'b0;
    logic       sel_user0 = 1'b0, sel_user1 = 1'b0;
    logic       dbe = 1'b0;
    logic       en_rom_bus, en_ram_bus, en_user_bus, en_board_xfer, en_user_xfer;
    int         tests = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    bufen_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .bus_status(bus_status),
        .blt_raw(blt_raw), .accel_sel(accel_sel), .sel_rom(sel_rom),
        .sel_sram(sel_sram), .sel_dram(sel_dram), .sel_user0(sel_user0),
        .sel_user1(sel_user1), .dbe(dbe), .en_rom_bus(en_rom_bus),
        .en_ram_bus(en_ram_bus), .en_user_bus(en_user_bus),
        .en_board_xfer(en_board_xfer), .en_user_xfer(en_user_xfer)
    );

    // Selects in order {rom, sram, dram, user0, user1}; drive at negedge.
    task automatic set_in(input logic [4:0] s, input logic acc, input logic d);
        @(negedge clk);
        {sel_rom, sel_sram, sel_dram, sel_user0, sel_user1} = s;
        accel_sel = acc;
        dbe = d;
        #2;
    endtask

    // Expected enables in order {rom, ram, user, board_x, user_x}.
    task automatic check(input logic [4:0] exp, input string req);
        logic [4:0] act;
        act = {en_rom_bus, en_ram_bus, en_user_bus, en_board_xfer, en_user_xfer};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: enables=%b expected=%b", req, act, exp);
        end
    endtask

    // Present one T1 with the given raw indication and status code.
    task automatic bus_cycle(input logic raw, input logic [3:0] st);
        @(negedge clk);
        cyc_start = 1'b1; blt_raw = raw; bus_status = st;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic t_reset;
        set_in(5'b00000, 1'b0, 1'b1);
        check(5'b10000, "R11 reset state, R3 no select");
        @(negedge clk); rst_n = 1'b1;
        #2 check(5'b10000, "R11 after release");
    endtask

    task automatic t_decode;
        set_in(5'b10000, 1'b0, 1'b1); check(5'b10000, "R3 rom select");
        set_in(5'b01000, 1'b0, 1'b1); check(5'b01000, "R4 sram");
        set_in(5'b00100, 1'b1, 1'b1); check(5'b01000, "R4 dram");
        set_in(5'b00010, 1'b0, 1'b1); check(5'b00100, "R5 user0");
        set_in(5'b00001, 1'b1, 1'b1); check(5'b00100, "R5 user1");
        set_in(5'b01001, 1'b0, 1'b1); check(5'b01000, "R5 ram wins over user, R10");
        set_in(5'b01000, 1'b0, 1'b0); check(5'b00000, "R9 dbe low normal mode");
    endtask

    task automatic t_block;
        bus_cycle(1'b1, 4'b1010);
        set_in(5'b10000, 1'b1, 1'b1); check(5'b00010, "R7 board crossover");
        set_in(5'b01000, 1'b1, 1'b1); check(5'b00000, "R6 R7 accel on ram, sram");
        set_in(5'b00100, 1'b0, 1'b1); check(5'b00001, "R8 user crossover dram");
        set_in(5'b01000, 1'b0, 1'b1); check(5'b00001, "R8 user crossover sram");
        set_in(5'b10000, 1'b0, 1'b1); check(5'b00000, "R8 R6 rom with user device");
        set_in(5'b00010, 1'b0, 1'b1); check(5'b00000, "R6 user select isolated");
        set_in(5'b10000, 1'b1, 1'b0); check(5'b00000, "R9 dbe low block mode");
    endtask

    task automatic t_hold;
        // Raw drops during T4, no cycle start: mode must hold.
        @(negedge clk); blt_raw = 1'b0; bus_status = 4'h0;
        @(negedge clk);
        set_in(5'b10000, 1'b1, 1'b1); check(5'b00010, "R1 hold across raw change");
        bus_cycle(1'b0, 4'b1010);
        set_in(5'b10000, 1'b1, 1'b1); check(5'b10000, "R1 R2 new cycle raw low");
        // Raw rises without a cycle start: still normal.
        @(negedge clk); blt_raw = 1'b1; bus_status = 4'b1011;
        @(negedge clk);
        set_in(5'b01000, 1'b0, 1'b1); check(5'b01000, "R1 raw rise ignored");
    endtask

    task automatic t_qualify;
        bus_cycle(1'b1, 4'b0110);
        set_in(5'b01000, 1'b0, 1'b1); check(5'b01000, "R2 status 0110 rejected");
        bus_cycle(1'b1, 4'b1000);
        set_in(5'b01000, 1'b0, 1'b1); check(5'b01000, "R2 status 1000 rejected");
        bus_cycle(1'b1, 4'b1011);
        set_in(5'b01000, 1'b0, 1'b1); check(5'b00001, "R2 status 1011 accepted");
    endtask

    task automatic t_reset_clears;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        set_in(5'b10000, 1'b1, 1'b1); check(5'b10000, "R11 reset clears block mode");
    endtask

    initial begin
        t_reset();
        t_decode();
        t_block();
        t_hold();
        t_qualify();
        t_reset_clears();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule